// File: doc/BRIEF.md
# Streaming Complex Matched-Filter Correlator

This block correlates a complex baseband stream against a fixed complex template of a known transmitted pulse. It accepts at most one complex sample per clock. An input strobe marks which cycles carry a sample. For each accepted sample it emits one complex, full-precision correlation result, flagged by an output strobe. The result is used downstream to find where the pulse sits in the received stream.

Accepted samples shift into a history register. Each history position feeds its own pipelined complex multiplier. The multiplier needs three real products instead of four, because it folds the coefficient sums into constants. A final registered stage adds all the tap products. No rounding or saturation is applied anywhere. Every intermediate value is sized so that it cannot wrap.

Top module: `cplx_corr_fir`

## Requirements
- R1: For each accepted sample x[n], the result equals the exact complex sum over k = 0..NTAPS-1 of c[k]·x[n-k]. Here x[n-k] is the k-th most recent accepted sample, and it counts as zero if fewer than k+1 samples were accepted since reset.
- R2: The coefficients are as follows. c[0] = -32768 - j32768. For k ≥ 1, Re c[k] = ((29k² + 7k + 3) mod 4001) - 2000 and Im c[k] = ((13k² + 17k + 5) mod 3001) - 1500. A unit impulse 1 + j0 followed by zeros therefore returns c[0], c[1], ... on successive results.
- R3: A cycle with `in_valid` low is ignored. Its data does not enter the history, and it produces no result.
- R4: `out_valid` is high in the cycle after the fifth rising edge, counting the edge that accepts a sample. It is high for exactly one cycle per accepted sample and low otherwise.
- R5: While `out_valid` is low, `out_re` and `out_im` keep their last values.
- R6: A synchronous active-high `rst` drives `out_valid` low and both outputs to zero, and it empties the sample history.
- R7: Full-scale inputs (components of -32768 and 32767 in any mix) give exact results in the 40-bit two's-complement outputs, with no wrap.
- R8: Each tap's three-multiply product equals the exact four-multiply complex product of its sample and coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High when the cycle carries a sample |
| in_re | input | 16 | Real part of the sample, signed |
| in_im | input | 16 | Imaginary part of the sample, signed |
| out_valid | output | 1 | High for one cycle per result |
| out_re | output | 40 | Real part of the correlation, signed |
| out_im | output | 40 | Imaginary part of the correlation, signed |

## Verification
The latency and hold properties assume three things about the inputs:
- `in_valid` is a defined level in every cycle after reset.
- Reset is applied at start-up.
- Sample values are known whenever the strobe is high.

The per-tap check also relies on the history outputs being defined from the first post-reset edge, which the synchronous clear guarantees. The stimulus holds `in_valid` low during reset and always drives defined data. It places random values on the data pins during idle cycles, so that ignoring them is actually exercised.

// File: rtl/cfir_pkg.sv
package cfir_pkg;

    // Clock edges from sample acceptance to a visible result
    localparam int LATENCY = 5;

    function automatic int coef_re(input int k);
        if (k == 0) return -32768;
        return ((k * k * 29 + k * 7 + 3) % 4001) - 2000;
    endfunction

    function automatic int coef_im(input int k);
        if (k == 0) return -32768;
        return ((k * k * 13 + k * 17 + 5) % 3001) - 1500;
    endfunction

endpackage

// File: rtl/cfir_delay.sv
module cfir_delay #(
    parameter int NTAPS = 64,
    parameter int W     = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                shift_en,
    input  logic signed [W-1:0] in_re,
    input  logic signed [W-1:0] in_im,
    output logic signed [W-1:0] tap_re [NTAPS],
    output logic signed [W-1:0] tap_im [NTAPS]
);

    logic signed [W-1:0] re_d [NTAPS];
    logic signed [W-1:0] re_q [NTAPS];
    logic signed [W-1:0] im_d [NTAPS];
    logic signed [W-1:0] im_q [NTAPS];

    always_comb begin
        re_d = re_q;
        im_d = im_q;
        if (shift_en) begin
            re_d[0] = in_re;
            im_d[0] = in_im;
            for (int k = 1; k < NTAPS; k++) begin
                re_d[k] = re_q[k-1];
                im_d[k] = im_q[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            re_q <= '{default: '0};
            im_q <= '{default: '0};
        end else begin
            re_q <= re_d;
            im_q <= im_d;
        end
    end

    assign tap_re = re_q;
    assign tap_im = im_q;

    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> ($stable(re_q[0]) && $stable(im_q[0]) && $stable(re_q[NTAPS-1])))
        else $error("history moved on an idle cycle"); // R3

endmodule

// File: rtl/cfir_tap.sv
module cfir_tap #(
    parameter int                   IN_W = 16,
    parameter int                   CW   = 16,
    parameter logic signed [CW-1:0] C_RE = '0,
    parameter logic signed [CW-1:0] C_IM = '0,
    localparam int                  MW   = IN_W + CW + 1,
    localparam int                  PW   = MW + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic signed [IN_W-1:0] x_re,
    input  logic signed [IN_W-1:0] x_im,
    output logic signed [PW-1:0]   p_re,
    output logic signed [PW-1:0]   p_im
);

    // Coefficient pre-adds fold into constants
    localparam logic signed [CW:0] C_SUM = (CW+1)'(C_RE) + (CW+1)'(C_IM);
    localparam logic signed [CW:0] C_DIF = (CW+1)'(C_IM) - (CW+1)'(C_RE);

    typedef struct packed {
        logic [IN_W:0]   sx;
        logic [IN_W-1:0] xr;
        logic [IN_W-1:0] xi;
        logic [MW-1:0]   k1;
        logic [MW-1:0]   k2;
        logic [MW-1:0]   k3;
        logic [PW-1:0]   pr;
        logic [PW-1:0]   pi;
        logic [1:0]      warm;
    } tap_st_t;

    tap_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        // stage A: data pre-add
        st_d.sx = (IN_W+1)'(x_re) + (IN_W+1)'(x_im);
        st_d.xr = x_re;
        st_d.xi = x_im;
        // stage B: three real products
        st_d.k1 = MW'($signed(st_q.sx)) * MW'(C_RE);
        st_d.k2 = MW'($signed(st_q.xi)) * MW'(C_SUM);
        st_d.k3 = MW'($signed(st_q.xr)) * MW'(C_DIF);
        // stage C: recombine
        st_d.pr = PW'($signed(st_q.k1)) - PW'($signed(st_q.k2));
        st_d.pi = PW'($signed(st_q.k1)) + PW'($signed(st_q.k3));
        st_d.warm = (st_q.warm == 2'd3) ? st_q.warm : st_q.warm + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign p_re = $signed(st_q.pr);
    assign p_im = $signed(st_q.pi);

    AST_TAP_EXACT_RE: assert property (@(posedge clk) disable iff (rst)
        (st_q.warm == 2'd3) |->
        ($signed(st_q.pr) == PW'($past(x_re, 3)) * PW'(C_RE) - PW'($past(x_im, 3)) * PW'(C_IM)))
        else $error("tap real product mismatch"); // R8

    AST_TAP_EXACT_IM: assert property (@(posedge clk) disable iff (rst)
        (st_q.warm == 2'd3) |->
        ($signed(st_q.pi) == PW'($past(x_re, 3)) * PW'(C_IM) + PW'($past(x_im, 3)) * PW'(C_RE)))
        else $error("tap imaginary product mismatch"); // R8

endmodule

// File: rtl/cfir_sum.sv
module cfir_sum #(
    parameter int NTAPS = 64,
    parameter int PW    = 34,
    parameter int OW    = 40
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic signed [PW-1:0] p_re [NTAPS],
    input  logic signed [PW-1:0] p_im [NTAPS],
    output logic signed [OW-1:0] y_re,
    output logic signed [OW-1:0] y_im
);

    typedef struct packed {
        logic [OW-1:0] re;
        logic [OW-1:0] im;
    } sum_st_t;

    sum_st_t st_d, st_q;
    logic signed [OW-1:0] acc_re, acc_im;

    always_comb begin
        acc_re = '0;
        acc_im = '0;
        for (int k = 0; k < NTAPS; k++) begin
            acc_re = acc_re + OW'(p_re[k]);
            acc_im = acc_im + OW'(p_im[k]);
        end
        st_d = st_q;
        if (load) begin
            st_d.re = acc_re;
            st_d.im = acc_im;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign y_re = $signed(st_q.re);
    assign y_im = $signed(st_q.im);

endmodule

// File: rtl/cplx_corr_fir.sv
module cplx_corr_fir #(
    parameter int  NTAPS = 64,
    parameter int  IN_W  = 16,
    parameter int  CW    = 16,
    localparam int PW    = IN_W + CW + 2,
    localparam int OW    = PW + $clog2(NTAPS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_re,
    input  logic signed [IN_W-1:0] in_im,
    output logic                   out_valid,
    output logic signed [OW-1:0]   out_re,
    output logic signed [OW-1:0]   out_im
);

    localparam int LAT = cfir_pkg::LATENCY;
    localparam int AW  = $clog2(LAT + 1);

    typedef struct packed {
        logic [LAT-1:0] v;
        logic [AW-1:0]  age;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic signed [IN_W-1:0] hist_re [NTAPS];
    logic signed [IN_W-1:0] hist_im [NTAPS];
    logic signed [PW-1:0]   prod_re [NTAPS];
    logic signed [PW-1:0]   prod_im [NTAPS];

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.v   = {ctl_q.v[LAT-2:0], in_valid};
        ctl_d.age = (ctl_q.age == AW'(LAT)) ? ctl_q.age : ctl_q.age + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    cfir_delay #(.NTAPS(NTAPS), .W(IN_W)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .shift_en (in_valid),
        .in_re    (in_re),
        .in_im    (in_im),
        .tap_re   (hist_re),
        .tap_im   (hist_im)
    );

    for (genvar g = 0; g < NTAPS; g++) begin : g_tap
        cfir_tap #(
            .IN_W (IN_W),
            .CW   (CW),
            .C_RE (CW'(cfir_pkg::coef_re(g))),
            .C_IM (CW'(cfir_pkg::coef_im(g)))
        ) u_tap (
            .clk  (clk),
            .rst  (rst),
            .x_re (hist_re[g]),
            .x_im (hist_im[g]),
            .p_re (prod_re[g]),
            .p_im (prod_im[g])
        );
    end

    cfir_sum #(.NTAPS(NTAPS), .PW(PW), .OW(OW)) u_sum (
        .clk  (clk),
        .rst  (rst),
        .load (ctl_q.v[LAT-2]),
        .p_re (prod_re),
        .p_im (prod_im),
        .y_re (out_re),
        .y_im (out_im)
    );

    assign out_valid = ctl_q.v[LAT-1];

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.age == AW'(LAT)) |-> (out_valid == $past(in_valid, LAT)))
        else $error("result strobe misaligned"); // R4

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((ctl_q.age != '0) && !out_valid) |-> ($stable(out_re) && $stable(out_im)))
        else $error("outputs changed without strobe"); // R5

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!out_valid && out_re == '0 && out_im == '0))
        else $error("reset left outputs set"); // R6

endmodule

// File: tb/cplx_corr_fir_bench.sv
`timescale 1ns/1ps
module cplx_corr_fir_bench;

    localparam int NT   = 64;
    localparam int DEPTH = 4096;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_re = '0;
    logic signed [15:0] in_im = '0;
    logic               out_valid;
    logic signed [39:0] out_re;
    logic signed [39:0] out_im;

    always #2 clk = ~clk;

    cplx_corr_fir u_cplx_corr_fir (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_re     (in_re),
        .in_im     (in_im),
        .out_valid (out_valid),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    longint hr [NT];
    longint hi [NT];
    bit     ev [DEPTH];
    longint er [DEPTH];
    longint ei [DEPTH];
    longint last_r = 0;
    longint last_i = 0;
    int     cyc = 0;
    string  tag = "R1";

    // R2 coefficient formula
    function automatic longint cr(input int k);
        if (k == 0) return -32768;
        return ((k * k * 29 + k * 7 + 3) % 4001) - 2000;
    endfunction

    function automatic longint ci(input int k);
        if (k == 0) return -32768;
        return ((k * k * 13 + k * 17 + 5) % 3001) - 1500;
    endfunction

    function automatic longint rnd16();
        return longint'($signed(16'($urandom)));
    endfunction

    task automatic check(input string rq, input longint act, input longint exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    task automatic observe();
        check("R4 out_valid", longint'(out_valid), longint'(ev[cyc]));
        if (ev[cyc]) begin
            check({tag, " out_re"}, out_re, er[cyc]);
            check({tag, " out_im"}, out_im, ei[cyc]);
            last_r = er[cyc];
            last_i = ei[cyc];
        end else begin
            check("R5 hold out_re", out_re, last_r);
            check("R5 hold out_im", out_im, last_i);
        end
    endtask

    task automatic step(input bit v, input longint xr, input longint xi);
        longint yr, yi;
        @(negedge clk);
        observe();
        in_valid = v;
        in_re    = 16'(xr);
        in_im    = 16'(xi);
        if (v) begin
            for (int k = NT - 1; k > 0; k--) begin
                hr[k] = hr[k-1];
                hi[k] = hi[k-1];
            end
            hr[0] = xr;
            hi[0] = xi;
            yr = 0;
            yi = 0;
            for (int k = 0; k < NT; k++) begin
                yr += cr(k) * hr[k] - ci(k) * hi[k];
                yi += cr(k) * hi[k] + ci(k) * hr[k];
            end
            ev[cyc + 5] = 1'b1;
            er[cyc + 5] = yr;
            ei[cyc + 5] = yi;
        end
        cyc++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R6 out_valid", longint'(out_valid), 0);
        check("R6 out_re", out_re, 0);
        check("R6 out_im", out_im, 0);
        cyc += 4;
        for (int j = 0; j < 8; j++) ev[cyc + j] = 1'b0;
        last_r = 0;
        last_i = 0;
        for (int k = 0; k < NT; k++) begin
            hr[k] = 0;
            hi[k] = 0;
        end
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R4 watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < NT; k++) begin
            hr[k] = 0;
            hi[k] = 0;
        end
        do_reset();

        // R2: impulse response walks the coefficient set
        tag = "R2";
        step(1'b1, 1, 0);
        for (int j = 0; j < NT + 2; j++) step(1'b1, 0, 0);

        // R1 and R8: dense random stream
        tag = "R1";
        for (int j = 0; j < 300; j++) step(1'b1, rnd16(), rnd16());

        // R3: sparse strobe with garbage on idle cycles
        tag = "R3";
        for (int j = 0; j < 400; j++) begin
            if ($urandom_range(1, 0) == 1) step(1'b1, rnd16(), rnd16());
            else                           step(1'b0, rnd16(), rnd16());
        end

        // R7: full-scale extremes
        tag = "R7";
        for (int j = 0; j < 70; j++) step(1'b1, -32768, -32768);
        for (int j = 0; j < 70; j++) begin
            if (j % 2 == 1) step(1'b1, 32767, -32768);
            else            step(1'b1, -32768, 32767);
        end
        for (int j = 0; j < 30; j++) step(1'b1, 32767, 32767);

        // R6: reset mid-stream empties the history
        tag = "R6";
        for (int j = 0; j < 40; j++) step(1'b1, rnd16(), rnd16());
        do_reset();
        step(1'b1, 100, -50);
        for (int j = 0; j < 20; j++) step(1'b1, 0, 0);

        tag = "R1";
        for (int j = 0; j < 12; j++) step(1'b0, 0, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule